// File: doc/BRIEF.md
# Hashed Page Table Walker

The walker resolves a virtual page when a page-translation cache misses. Given a virtual segment identifier, an effective address and a storage-description word, it builds a hash, reads up to two groups of eight page table entries from memory and looks for one whose tag matches the request. Memory is reached through a single word-wide request channel whose completion is signalled by an acknowledge, so any number of wait cycles may pass per access.

When an entry matches, the walker fetches the second word of that entry and returns it together with its byte address. If the entry's referenced flag is still clear, it first writes that word back with the flag set. If no entry of either group matches, the walker reports a miss. Each finished walk raises `done_o` for one cycle. The caller must wait for it before a new request is accepted.

Top module: `ptw_top`

## Requirements
- R1: The primary hash is `vsid[18:0] XOR {3'b0, ea[27:12]}`. The first group lies at byte address `{sdr[31:16], 16'b0} | ((hash & {sdr[8:0], 10'h3FF}) << 6)`. Bit numbering is LSB-0. The first memory request of a walk reads this address.
- R2: The second group uses the bitwise complement of the 19-bit primary hash, with the same origin and mask. It is searched only after all 8 entries of the first group have failed.
- R3: Entry word 0 is laid out as valid = bit 31, VSID = bits 30:7, pass select = bit 6, abbreviated page index = bits 5:0. An entry matches only when valid is 1, the pass select equals the pass (0 first, 1 second), the VSID equals `vsid_i` and the abbreviated index equals `ea[27:22]`.
- R4: Entries are read in ascending address order, 8 bytes apart. The scan stops at the first matching entry, and later matches in the group are not returned.
- R5: On a match, word 1 is read at entry address + 4. `hit_o` is raised, `pte1_addr_o` holds that address and `pte1_o` holds word 1 with bit 8 (referenced) set.
- R6: If bit 8 of word 1 was clear, exactly one write to entry address + 4 stores word 1 with bit 8 set. If bit 8 was already set, no write occurs.
- R7: If neither group matches after 16 word-0 reads, `miss_o` is raised and no write occurs.
- R8: `done_o` lasts exactly one cycle and comes with exactly one of `hit_o` and `miss_o`.
- R9: `busy_o` rises in the cycle after an accepted start and stays high until the walk finishes. A start while busy is ignored and produces no further result.
- R10: `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold steady until `mem_ack_i`. Any number of wait cycles is tolerated.
- R11: After reset, `busy_o`, `done_o` and `mem_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| vsid_i | input | 24 | Virtual segment identifier |
| ea_i | input | 32 | Effective address |
| sdr_i | input | 32 | Table origin (31:16) and upper hash mask (8:0) |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| hit_o | output | 1 | Walk found an entry (with done_o) |
| miss_o | output | 1 | Walk found no entry (with done_o) |
| pte1_o | output | 32 | Word 1 of the found entry, referenced bit set |
| pte1_addr_o | output | 32 | Byte address of that word |
| mem_req_o | output | 1 | Memory request pending |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Request byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |

## Verification
Each group is filled with near-miss entries: one cleared valid bit, one wrong pass select, one VSID differing only above the hashed bits, and one wrong abbreviated index. A walker that ignored any of these fields would return the wrong word 1 or stop too early. A second true match is placed after the target, and the word-0 read count is checked, so a design that scanned out of order or kept going after a hit shows up as a wrong word or a wrong count.

Mask settings range from none to all upper hash bits. This catches a hash or group address built from the wrong bits, because the first request address would be wrong. The referenced bit is tested both clear and already set; a walker that always or never wrote back gives a wrong write count. A start is also pulsed in the middle of a walk, which a design that relatched its inputs would answer with a second result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int WORD_W   = 32;
  localparam int VSID_W   = 24;
  localparam int API_W    = 6;
  localparam int PIDX_W   = 16;
  localparam int HASH_W   = 19;
  localparam int ORIG_W   = 16;
  localparam int HMASK_W  = 9;
  localparam int ENTRY_B  = 8;
  localparam int REF_POS  = 8;

  typedef struct packed {
    logic              valid;
    logic [VSID_W-1:0] vsid;
    logic              hsel;
    logic [API_W-1:0]  api;
  } pte_hi_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TAG,
    ST_DATA,
    ST_MARK
  } walk_st_e;
endpackage

// File: rtl/ptw_hash.sv
module ptw_hash
  import ptw_pkg::*;
#(
  parameter int GRP_SHIFT = 6
) (
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [WORD_W-1:0] ea_i,
  input  logic [WORD_W-1:0] sdr_i,
  input  logic              pass_i,
  output logic [WORD_W-1:0] group_base_o
);
  localparam int LOW_HASH = WORD_W - ORIG_W - GRP_SHIFT;
  localparam int PIDX_LSB = WORD_W - 4 - PIDX_W;

  logic [PIDX_W-1:0] pidx;
  logic [HASH_W-1:0] hash_p, hash, hmask;
  logic [WORD_W-1:0] hashed;

  assign pidx   = ea_i[PIDX_LSB +: PIDX_W];
  assign hash_p = vsid_i[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, pidx};
  assign hash   = pass_i ? ~hash_p : hash_p;
  assign hmask  = {sdr_i[HMASK_W-1:0], {LOW_HASH{1'b1}}};
  assign hashed = {{(WORD_W-HASH_W){1'b0}}, hash & hmask} << GRP_SHIFT;

  assign group_base_o = {sdr_i[WORD_W-1 -: ORIG_W], {(WORD_W-ORIG_W){1'b0}}} | hashed;
endmodule

// File: rtl/ptw_match.sv
module ptw_match
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:0] word0_i,
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [API_W-1:0]  api_i,
  input  logic              pass_i,
  output logic              hit_o
);
  pte_hi_t e;
  assign e     = pte_hi_t'(word0_i);
  assign hit_o = e.valid && (e.hsel == pass_i) && (e.vsid == vsid_i) && (e.api == api_i);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int GRP_ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [WORD_W-1:0] ea_i,
  input  logic [WORD_W-1:0] sdr_i,
  input  logic [WORD_W-1:0] group_base_i,
  input  logic              tag_hit_i,
  output logic [VSID_W-1:0] vsid_q_o,
  output logic [WORD_W-1:0] ea_q_o,
  output logic [WORD_W-1:0] sdr_q_o,
  output logic              pass_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic [WORD_W-1:0] pte1_o,
  output logic [WORD_W-1:0] pte1_addr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int SLOT_W      = $clog2(GRP_ENTRIES);
  localparam int ENTRY_SHIFT = $clog2(ENTRY_B);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GRP_ENTRIES - 1);
  localparam logic [WORD_W-1:0] W1_OFS    = WORD_W'(ENTRY_B / 2);
  localparam logic [WORD_W-1:0] REF_MASK  = WORD_W'(1) << REF_POS;

  walk_st_e          state_q;
  logic              pass_q;
  logic [SLOT_W-1:0] slot_q;
  logic [VSID_W-1:0] vsid_q;
  logic [WORD_W-1:0] ea_q, sdr_q, mark_q;
  logic              done_q, hit_q, miss_q;
  logic [WORD_W-1:0] pte1_q, pte1_addr_q;
  logic [WORD_W-1:0] entry_addr, data_set;

  assign entry_addr = group_base_i | (WORD_W'(slot_q) << ENTRY_SHIFT);
  assign data_set   = mem_rdata_i | REF_MASK;

  always_comb begin
    mem_req_o   = (state_q != ST_IDLE);
    mem_we_o    = (state_q == ST_MARK);
    mem_wdata_o = mark_q;
    mem_addr_o  = (state_q == ST_TAG) ? entry_addr : (entry_addr | W1_OFS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pass_q      <= 1'b0;
      slot_q      <= '0;
      vsid_q      <= '0;
      ea_q        <= '0;
      sdr_q       <= '0;
      mark_q      <= '0;
      done_q      <= 1'b0;
      hit_q       <= 1'b0;
      miss_q      <= 1'b0;
      pte1_q      <= '0;
      pte1_addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          vsid_q  <= vsid_i;
          ea_q    <= ea_i;
          sdr_q   <= sdr_i;
          pass_q  <= 1'b0;
          slot_q  <= '0;
          state_q <= ST_TAG;
        end
        ST_TAG: if (mem_ack_i) begin
          if (tag_hit_i) begin
            state_q <= ST_DATA;
          end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
            if (!pass_q) begin
              pass_q <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              miss_q  <= 1'b1;
            end
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        ST_DATA: if (mem_ack_i) begin
          pte1_q      <= data_set;
          pte1_addr_q <= mem_addr_o;
          if (mem_rdata_i[REF_POS]) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            hit_q   <= 1'b1;
          end else begin
            mark_q  <= data_set;
            state_q <= ST_MARK;
          end
        end
        ST_MARK: if (mem_ack_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          hit_q   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign vsid_q_o    = vsid_q;
  assign ea_q_o      = ea_q;
  assign sdr_q_o     = sdr_q;
  assign pass_o      = pass_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign hit_o       = hit_q;
  assign miss_o      = miss_q;
  assign pte1_o      = pte1_q;
  assign pte1_addr_o = pte1_addr_q;

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));
  a_r8_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hit_o ^ miss_o));
  a_r8_kind_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o || miss_o) |-> done_o);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_mark_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[REF_POS] && mem_addr_o[ENTRY_SHIFT-1]);
  a_r2_pass_after_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_q) |-> $past(slot_q) == LAST_SLOT);
  a_r9_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r7_miss_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> !$past(mem_we_o));
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int GRP_ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [23:0]       vsid_i,
  input  logic [31:0]       ea_i,
  input  logic [31:0]       sdr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic [31:0]       pte1_o,
  output logic [31:0]       pte1_addr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  localparam int GRP_SHIFT = $clog2(GRP_ENTRIES * ENTRY_B);
  localparam int API_LSB   = WORD_W - 4 - API_W;

  logic [VSID_W-1:0] vsid_q;
  logic [WORD_W-1:0] ea_q, sdr_q, group_base;
  logic              pass, tag_hit;

  ptw_hash #(.GRP_SHIFT(GRP_SHIFT)) i_hash (
    .vsid_i       (vsid_q),
    .ea_i         (ea_q),
    .sdr_i        (sdr_q),
    .pass_i       (pass),
    .group_base_o (group_base)
  );

  ptw_match i_match (
    .word0_i (mem_rdata_i),
    .vsid_i  (vsid_q),
    .api_i   (ea_q[API_LSB +: API_W]),
    .pass_i  (pass),
    .hit_o   (tag_hit)
  );

  ptw_ctrl #(.GRP_ENTRIES(GRP_ENTRIES)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .vsid_i       (vsid_i),
    .ea_i         (ea_i),
    .sdr_i        (sdr_i),
    .group_base_i (group_base),
    .tag_hit_i    (tag_hit),
    .vsid_q_o     (vsid_q),
    .ea_q_o       (ea_q),
    .sdr_q_o      (sdr_q),
    .pass_o       (pass),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .hit_o        (hit_o),
    .miss_o       (miss_o),
    .pte1_o       (pte1_o),
    .pte1_addr_o  (pte1_addr_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i)
  );

  a_r3_low_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);
endmodule

// File: tb/test_ptw_top.sv
module test_ptw_top;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [23:0] vsid;
    logic [31:0] ea;
    logic [31:0] sdr;
    logic [1:0]  where;   // 0 first group, 1 second group, 2 none
    logic [2:0]  slot;
    logic        refset;
    logic [1:0]  lat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{24'hA53C71, 32'h12345678, 32'h004001FF, 2'd0, 3'd0, 1'b0, 2'd0},
    '{24'h0FF00F, 32'h0ABCD000, 32'h01000000, 2'd0, 3'd7, 1'b1, 2'd2},
    '{24'hF00001, 32'h7FFFF123, 32'h02000055, 2'd1, 3'd3, 1'b0, 2'd1},
    '{24'h123456, 32'h00000000, 32'h800001FF, 2'd1, 3'd7, 1'b1, 2'd3},
    '{24'h000000, 32'hFFFFFFFF, 32'h00100003, 2'd2, 3'd0, 1'b0, 2'd1},
    '{24'h7ABCDE, 32'h31415926, 32'h0F0000F0, 2'd0, 3'd4, 1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] vsid_i = '0;
  logic [31:0] ea_i = '0, sdr_i = '0;
  logic        busy_o, done_o, hit_o, miss_o, mem_req_o, mem_we_o;
  logic [31:0] pte1_o, pte1_addr_o, mem_addr_o, mem_wdata_o;
  logic        mem_ack_i;
  logic [31:0] mem_rdata_i;

  logic [31:0] mem [logic [31:0]];
  int lat = 0;
  int cnt, rd_cnt, wr_cnt, done_cnt;
  logic [31:0] last_wa, last_wd;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  ptw_top i_ptw_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .vsid_i(vsid_i), .ea_i(ea_i), .sdr_i(sdr_i),
    .busy_o(busy_o), .done_o(done_o), .hit_o(hit_o), .miss_o(miss_o),
    .pte1_o(pte1_o), .pte1_addr_o(pte1_addr_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  // memory responder with programmable wait cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack_i <= 1'b0; mem_rdata_i <= '0; cnt <= 0;
      rd_cnt <= 0; wr_cnt <= 0; done_cnt <= 0; last_wa <= '0; last_wd <= '0;
    end else begin
      if (done_o) done_cnt <= done_cnt + 1;
      if (mem_ack_i) begin
        mem_ack_i <= 1'b0; cnt <= 0;
      end else if (mem_req_o) begin
        if (cnt >= lat) begin
          mem_ack_i <= 1'b1; cnt <= 0;
          if (mem_we_o) begin
            mem[mem_addr_o] = mem_wdata_o;
            wr_cnt <= wr_cnt + 1; last_wa <= mem_addr_o; last_wd <= mem_wdata_o;
          end else begin
            mem_rdata_i <= mem.exists(mem_addr_o) ? mem[mem_addr_o] : 32'h0;
            rd_cnt <= rd_cnt + 1;
          end
        end else cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] grp(input logic [23:0] v, input logic [31:0] ea,
                                      input logic [31:0] sdr, input logic pass);
    logic [18:0] h;
    h = v[18:0] ^ {3'b000, ea[27:12]};
    if (pass) h = ~h;
    return {sdr[31:16] | {7'b0, h[18:10] & sdr[8:0]}, h[9:0], 6'b0};
  endfunction

  function automatic logic [31:0] w0(input logic val, input logic [23:0] v, input logic h, input logic [5:0] api);
    return {val, v, h, api};
  endfunction

  task automatic fill(input logic [31:0] base, input logic pass, input logic [23:0] v,
                      input logic [5:0] api, input int tslot, input logic [31:0] tw1);
    for (int j = 0; j < 8; j++) begin
      logic [31:0] a;
      a = base + 32'(j * 8);
      if (j == tslot) begin
        mem[a] = w0(1'b1, v, pass, api); mem[a + 4] = tw1;
      end else if (tslot >= 0 && j == tslot + 1) begin
        mem[a] = w0(1'b1, v, pass, api); mem[a + 4] = 32'h0BAD0001;
      end else begin
        case (j % 4)
          0: mem[a] = w0(1'b0, v, pass, api);
          1: mem[a] = w0(1'b1, v, ~pass, api);
          2: mem[a] = w0(1'b1, v ^ 24'h100000, pass, api);
          default: mem[a] = w0(1'b1, v, pass, api ^ 6'h01);
        endcase
        mem[a + 4] = 32'hDEAD0000 | 32'(j);
      end
    end
  endtask

  task automatic prep(input vec_t v, input int idx, output logic [31:0] pg,
                      output logic [31:0] sg, output logic [31:0] tw1);
    mem.delete();
    pg  = grp(v.vsid, v.ea, v.sdr, 1'b0);
    sg  = grp(v.vsid, v.ea, v.sdr, 1'b1);
    tw1 = (32'h5A5A3002 ^ (32'(idx) << 12)) | (v.refset ? 32'h100 : 32'h0);
    fill(pg, 1'b0, v.vsid, v.ea[27:22], (v.where == 2'd0) ? int'(v.slot) : -1, tw1);
    fill(sg, 1'b1, v.vsid, v.ea[27:22], (v.where == 2'd1) ? int'(v.slot) : -1, tw1);
    lat = int'(v.lat);
  endtask

  task automatic kick(input logic [23:0] v, input logic [31:0] ea, input logic [31:0] sdr);
    @(negedge clk);
    start_i = 1'b1; vsid_i = v; ea_i = ea; sdr_i = sdr;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk); n++;
    end
    if (!done_o) chk(1'b0, "R9 walk timeout", 32'(n), 32'd2000);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pg, sg, tw1, eaddr, epte;
    int rd0, wr0, d0, ereads;
    repeat (3) @(negedge clk);
    chk(!busy_o, "R11 busy after reset", 32'(busy_o), 32'h0);
    chk(!done_o, "R11 done after reset", 32'(done_o), 32'h0);
    chk(!mem_req_o, "R11 req after reset", 32'(mem_req_o), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      prep(VECS[i], i, pg, sg, tw1);
      rd0 = rd_cnt; wr0 = wr_cnt;
      kick(VECS[i].vsid, VECS[i].ea, VECS[i].sdr);
      chk(busy_o, "R9 busy after start", 32'(busy_o), 32'h1);
      chk(mem_req_o && mem_addr_o == pg, "R1 first group address", mem_addr_o, pg);
      wait_done();
      if (VECS[i].where != 2'd2) begin
        eaddr  = ((VECS[i].where == 2'd1) ? sg : pg) + 32'(VECS[i].slot) * 8 + 4;
        epte   = tw1 | 32'h100;
        ereads = ((VECS[i].where == 2'd1) ? 8 : 0) + int'(VECS[i].slot) + 2;
        chk(hit_o && !miss_o, "R3 hit flag", {hit_o, miss_o}, 32'h2);
        chk(pte1_o == epte, "R5 word1 value", pte1_o, epte);
        chk(pte1_addr_o == eaddr, "R5 word1 address", pte1_addr_o, eaddr);
        chk(rd_cnt - rd0 == ereads, (VECS[i].where == 2'd1) ? "R2 read count" : "R4 read count",
            32'(rd_cnt - rd0), 32'(ereads));
        if (VECS[i].refset) begin
          chk(wr_cnt == wr0, "R6 no write when set", 32'(wr_cnt - wr0), 32'h0);
        end else begin
          chk(wr_cnt - wr0 == 1, "R6 one write", 32'(wr_cnt - wr0), 32'h1);
          chk(last_wa == eaddr, "R6 write address", last_wa, eaddr);
          chk(last_wd == epte, "R6 write data", last_wd, epte);
        end
      end else begin
        chk(miss_o && !hit_o, "R7 miss flag", {hit_o, miss_o}, 32'h1);
        chk(rd_cnt - rd0 == 16, "R7 read count", 32'(rd_cnt - rd0), 32'd16);
        chk(wr_cnt == wr0, "R7 no write", 32'(wr_cnt - wr0), 32'h0);
      end
      @(negedge clk);
      chk(!done_o && !hit_o && !miss_o, "R8 pulse width", {done_o, hit_o, miss_o}, 32'h0);
    end

    // start pulsed during a walk is ignored
    prep(VECS[2], 2, pg, sg, tw1);
    lat = 2;
    d0 = done_cnt;
    kick(VECS[2].vsid, VECS[2].ea, VECS[2].sdr);
    repeat (2) @(negedge clk);
    start_i = 1'b1; vsid_i = VECS[0].vsid; ea_i = VECS[0].ea; sdr_i = VECS[0].sdr;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    eaddr = sg + 32'(VECS[2].slot) * 8 + 4;
    chk(hit_o, "R9 original walk hits", 32'(hit_o), 32'h1);
    chk(pte1_addr_o == eaddr, "R9 original address", pte1_addr_o, eaddr);
    repeat (20) @(negedge clk);
    chk(!busy_o, "R9 idle after walk", 32'(busy_o), 32'h0);
    chk(done_cnt - d0 == 1, "R9 single result", 32'(done_cnt - d0), 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule